// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiply Unit

This unit multiplies two 8-bit operands and returns a 16-bit product for a register pair, together with an updated status byte. It supports three operand interpretations: both unsigned, both two's complement, or a signed first operand times an unsigned second operand. Each interpretation also has a fractional variant, where the product is shifted left by one bit to keep fixed-point scaling in a 1.7 by 1.7 format.

The instruction decoder sends the operand values, the register numbers they were read from, a mode code, the current status byte and a single-cycle start strobe. The unit checks the register numbers against the range the chosen mode allows. It is a two-stage pipeline, so a new start may arrive on every cycle. A legal request ends with a one-cycle `done`, the product and the new status byte. A request that breaks a register-range rule, or that uses the reserved mode code, ends with a one-cycle `illegal`, and nothing is written.

Top module: `mul_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `done`, `illegal`, `product` and `sr_out` are all zero.
- R2: Mode 0 (mode[1:0]=0, mode[2]=0) multiplies both operands as unsigned values and accepts any register numbers 0..31.
- R3: Mode 1 treats both operands as two's complement and is legal only when both register numbers are in 16..31.
- R4: Mode 2 treats `dst_val` as signed and `src_val` as unsigned and is legal only when both register numbers are in 16..23.
- R5: Bit 1 of `sr_out` (zero flag) is set exactly when the delivered 16-bit `product` is zero.
- R6: Bits 7..2 of `sr_out` equal the corresponding bits of `sr_in` as sampled with `start`, so a later change of `sr_in` has no effect on them.
- R7: Bit 0 of `sr_out` (carry flag) equals bit 15 of the product before any fractional shift.
- R8: `done` is high for one cycle, exactly two rising edges after the edge that samples `start` (the sampling edge included), and never without a start.
- R9: Setting mode[2] selects the fractional variant of modes 0, 1 and 2. It forms the same product and shifts it left by one bit, dropping the old bit 15. It is legal only when both register numbers are in 16..23.
- R10: A request with mode[1:0]=3, or with a register number outside its mode's range, pulses `illegal` instead of `done` with the same latency. `product` and `sr_out` keep their previous values.
- R11: Starts on consecutive cycles give results on consecutive cycles, in issue order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Single-cycle request strobe |
| mode | input | 3 | [1:0] operand interpretation, [2] fractional |
| dst_idx | input | 5 | Register number of the first operand |
| src_idx | input | 5 | Register number of the second operand |
| dst_val | input | 8 | First operand value |
| src_val | input | 8 | Second operand value |
| sr_in | input | 8 | Incoming status byte |
| done | output | 1 | Result valid pulse |
| illegal | output | 1 | Rejected request pulse |
| product | output | 16 | Product: low byte to r0, high byte to r1 |
| sr_out | output | 8 | Status byte with zero and carry updated |

## Verification
The bench builds the unit with its default parameters: 8-bit operands, 5-bit register numbers, an upper bank starting at 16 and a narrow bank ending at 23. With these values it can reach the exact register boundaries 15/16, 23/24 and 31 in each mode family. The operand table covers the sign corners 0x80 and 0xFF, where the signed, mixed and unsigned readings give different products and different carries. It also covers the fractional shift that moves a nonzero bit 14 into bit 15.

// File: rtl/mul_pkg.sv
package mul_pkg;

    localparam int OPND_W   = 8;
    localparam int REGNUM_W = 5;
    localparam int STAT_W   = 8;
    localparam int ZF_POS   = 1;
    localparam int CF_POS   = 0;

    typedef enum logic [1:0] {
        KIND_UU  = 2'd0,
        KIND_SS  = 2'd1,
        KIND_SU  = 2'd2,
        KIND_BAD = 2'd3
    } kind_e;

    typedef struct packed {
        logic  frac;
        kind_e kind;
    } mode_t;

    function automatic logic first_is_signed(mode_t m);
        return (m.kind == KIND_SS) || (m.kind == KIND_SU);
    endfunction

    function automatic logic second_is_signed(mode_t m);
        return (m.kind == KIND_SS);
    endfunction

endpackage

// File: rtl/mul_decode.sv
module mul_decode
    import mul_pkg::*;
#(
    parameter int OPW        = OPND_W,
    parameter int RNW        = REGNUM_W,
    parameter int SRW        = STAT_W,
    parameter int UPPER_BASE = 16,
    parameter int NARROW_TOP = 23
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  mode_t          mode,
    input  logic [RNW-1:0] dst_idx,
    input  logic [RNW-1:0] src_idx,
    input  logic [OPW-1:0] dst_val,
    input  logic [OPW-1:0] src_val,
    input  logic [SRW-1:0] sr_in,
    output logic           s1_valid,
    output logic           s1_bad,
    output mode_t          s1_mode,
    output logic [OPW-1:0] s1_a,
    output logic [OPW-1:0] s1_b,
    output logic [SRW-1:0] s1_sr
);

    localparam logic [RNW-1:0] LO_LIM = RNW'(UPPER_BASE);
    localparam logic [RNW-1:0] HI_LIM = RNW'(NARROW_TOP);

    logic dst_upper, src_upper, dst_narrow, src_narrow, legal;

    always_comb begin
        dst_upper  = (dst_idx >= LO_LIM);
        src_upper  = (src_idx >= LO_LIM);
        dst_narrow = dst_upper && (dst_idx <= HI_LIM);
        src_narrow = src_upper && (src_idx <= HI_LIM);
        if (mode.kind == KIND_BAD)
            legal = 1'b0;
        else if (!mode.frac && mode.kind == KIND_UU)
            legal = 1'b1;
        else if (!mode.frac && mode.kind == KIND_SS)
            legal = dst_upper && src_upper;
        else
            legal = dst_narrow && src_narrow;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_bad   <= 1'b0;
            s1_mode  <= '{frac: 1'b0, kind: KIND_UU};
            s1_a     <= '0;
            s1_b     <= '0;
            s1_sr    <= '0;
        end else begin
            s1_valid <= start;
            s1_bad   <= start && !legal;
            if (start) begin
                s1_mode <= mode;
                s1_a    <= dst_val;
                s1_b    <= src_val;
                s1_sr   <= sr_in;
            end
        end
    end

endmodule

// File: rtl/mul_core.sv
module mul_core
    import mul_pkg::*;
#(
    parameter int OPW = OPND_W
) (
    input  mode_t            mode,
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    output logic [2*OPW-1:0] raw,
    output logic [2*OPW-1:0] res
);

    localparam int PW = 2 * OPW;

    logic [PW-1:0] a_ext, b_ext;
    logic [PW-1:0] pp [PW];

    always_comb begin
        a_ext = {{OPW{first_is_signed(mode) & a[OPW-1]}}, a};
        b_ext = {{OPW{second_is_signed(mode) & b[OPW-1]}}, b};
    end

    for (genvar i = 0; i < PW; i++) begin : g_row
        assign pp[i] = b_ext[i] ? (a_ext << i) : '0;
    end

    always_comb begin
        raw = '0;
        for (int i = 0; i < PW; i++)
            raw = raw + pp[i];
        res = mode.frac ? {raw[PW-2:0], 1'b0} : raw;
    end

endmodule

// File: rtl/mul_flags.sv
module mul_flags #(
    parameter int SRW   = 8,
    parameter int PW    = 16,
    parameter int Z_POS = 1,
    parameter int C_POS = 0
) (
    input  logic [SRW-1:0] sr_in,
    input  logic           raw_msb,
    input  logic [PW-1:0]  res,
    output logic [SRW-1:0] sr_out
);

    always_comb begin
        sr_out        = sr_in;
        sr_out[Z_POS] = (res == '0);
        sr_out[C_POS] = raw_msb;
    end

endmodule

// File: rtl/mul_unit.sv
module mul_unit
    import mul_pkg::*;
#(
    parameter int OPW        = OPND_W,
    parameter int RNW        = REGNUM_W,
    parameter int SRW        = STAT_W,
    parameter int Z_POS      = ZF_POS,
    parameter int C_POS      = CF_POS,
    parameter int UPPER_BASE = 16,
    parameter int NARROW_TOP = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [RNW-1:0]   dst_idx,
    input  logic [RNW-1:0]   src_idx,
    input  logic [OPW-1:0]   dst_val,
    input  logic [OPW-1:0]   src_val,
    input  logic [SRW-1:0]   sr_in,
    output logic             done,
    output logic             illegal,
    output logic [2*OPW-1:0] product,
    output logic [SRW-1:0]   sr_out
);

    localparam int PW = 2 * OPW;

    mode_t          req_mode, s1_mode;
    logic           s1_valid, s1_bad;
    logic [OPW-1:0] s1_a, s1_b;
    logic [SRW-1:0] s1_sr, sr_next;
    logic [PW-1:0]  raw, res;

    assign req_mode = mode_t'(mode);

    mul_decode #(
        .OPW(OPW), .RNW(RNW), .SRW(SRW),
        .UPPER_BASE(UPPER_BASE), .NARROW_TOP(NARROW_TOP)
    ) decode_i (
        .clk(clk), .rst(rst), .start(start), .mode(req_mode),
        .dst_idx(dst_idx), .src_idx(src_idx),
        .dst_val(dst_val), .src_val(src_val), .sr_in(sr_in),
        .s1_valid(s1_valid), .s1_bad(s1_bad), .s1_mode(s1_mode),
        .s1_a(s1_a), .s1_b(s1_b), .s1_sr(s1_sr)
    );

    mul_core #(.OPW(OPW)) core_i (
        .mode(s1_mode), .a(s1_a), .b(s1_b), .raw(raw), .res(res)
    );

    mul_flags #(.SRW(SRW), .PW(PW), .Z_POS(Z_POS), .C_POS(C_POS)) flags_i (
        .sr_in(s1_sr), .raw_msb(raw[PW-1]), .res(res), .sr_out(sr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done    <= 1'b0;
            illegal <= 1'b0;
            product <= '0;
            sr_out  <= '0;
        end else begin
            done    <= s1_valid && !s1_bad;
            illegal <= s1_valid && s1_bad;
            if (s1_valid && !s1_bad) begin
                product <= res;
                sr_out  <= sr_next;
            end
        end
    end

endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
    parameter int OPW   = 8,
    parameter int SRW   = 8,
    parameter int Z_POS = 1,
    parameter int C_POS = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [2:0]       mode,
    input logic [SRW-1:0]   sr_in,
    input logic             done,
    input logic             illegal,
    input logic [2*OPW-1:0] product,
    input logic [SRW-1:0]   sr_out
);

    localparam logic [SRW-1:0] KEEP =
        ~((SRW'(1) << Z_POS) | (SRW'(1) << C_POS));

    a_r8_done_needs_start: assert property (@(posedge clk) disable iff (rst)
        (done || illegal) |-> $past(start, 2));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && illegal));

    a_r10_hold_on_reject: assert property (@(posedge clk) disable iff (rst)
        illegal |-> ($stable(product) && $stable(sr_out)));

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
        done |-> (sr_out[Z_POS] == (product == '0)));

    a_r6_flags_kept: assert property (@(posedge clk) disable iff (rst)
        done |-> ((sr_out & KEEP) == ($past(sr_in, 2) & KEEP)));

    a_r7_carry_integer: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(mode[2], 2)) |-> (sr_out[C_POS] == product[2*OPW-1]));

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!done && !illegal));

endmodule

bind mul_unit mul_unit_chk #(
    .OPW(OPW), .SRW(SRW), .Z_POS(Z_POS), .C_POS(C_POS)
) chk_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .sr_in(sr_in),
    .done(done), .illegal(illegal), .product(product), .sr_out(sr_out)
);

// File: tb/mul_unit_tb_top.sv
module mul_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  mode = '0;
    logic [4:0]  dst_idx = '0, src_idx = '0;
    logic [7:0]  dst_val = '0, src_val = '0, sr_in = '0;
    logic        done, illegal;
    logic [15:0] product;
    logic [7:0]  sr_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] last_prod = '0;
    logic [7:0]  last_sr   = '0;

    always #2.5 clk = ~clk;

    mul_unit dut_i (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .dst_idx(dst_idx), .src_idx(src_idx),
        .dst_val(dst_val), .src_val(src_val), .sr_in(sr_in),
        .done(done), .illegal(illegal), .product(product), .sr_out(sr_out)
    );

    // {mode, dst_idx, src_idx, dst_val, src_val, sr_in, product, carry, illegal}
    localparam int NV = 17;
    localparam logic [54:0] VEC [NV] = '{
        {3'd0, 5'd2,  5'd3,  8'h0C, 8'h0A, 8'h00, 16'h0078, 1'b0, 1'b0},
        {3'd0, 5'd0,  5'd31, 8'hFF, 8'hFF, 8'hF0, 16'hFE01, 1'b1, 1'b0},
        {3'd0, 5'd7,  5'd9,  8'h00, 8'h55, 8'hFF, 16'h0000, 1'b0, 1'b0},
        {3'd1, 5'd16, 5'd31, 8'hFF, 8'h02, 8'h00, 16'hFFFE, 1'b1, 1'b0},
        {3'd1, 5'd20, 5'd17, 8'h80, 8'h80, 8'h3C, 16'h4000, 1'b0, 1'b0},
        {3'd2, 5'd16, 5'd23, 8'hFF, 8'hFF, 8'h00, 16'hFF01, 1'b1, 1'b0},
        {3'd2, 5'd23, 5'd16, 8'h7F, 8'h80, 8'h00, 16'h3F80, 1'b0, 1'b0},
        {3'd4, 5'd18, 5'd19, 8'h80, 8'h80, 8'h00, 16'h8000, 1'b0, 1'b0},
        {3'd5, 5'd16, 5'd23, 8'h80, 8'h80, 8'h00, 16'h8000, 1'b0, 1'b0},
        {3'd5, 5'd17, 5'd18, 8'h40, 8'hC0, 8'h00, 16'hE000, 1'b1, 1'b0},
        {3'd6, 5'd20, 5'd21, 8'h80, 8'h02, 8'h00, 16'hFE00, 1'b1, 1'b0},
        {3'd1, 5'd15, 5'd16, 8'h11, 8'h22, 8'h00, 16'h0000, 1'b0, 1'b1},
        {3'd2, 5'd16, 5'd24, 8'h11, 8'h22, 8'h00, 16'h0000, 1'b0, 1'b1},
        {3'd5, 5'd24, 5'd16, 8'h11, 8'h22, 8'h00, 16'h0000, 1'b0, 1'b1},
        {3'd3, 5'd16, 5'd16, 8'h11, 8'h22, 8'h00, 16'h0000, 1'b0, 1'b1},
        {3'd0, 5'd31, 5'd30, 8'h03, 8'h05, 8'h00, 16'h000F, 1'b0, 1'b0},
        {3'd4, 5'd23, 5'd16, 8'hFF, 8'hFF, 8'h00, 16'hFC02, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sr(input logic [7:0] fin,
                                          input logic [15:0] p, input logic c);
        return (fin & 8'hFC) | {6'b0, (p == 16'h0), c};
    endfunction

    task automatic run_vec(input logic [54:0] v, input int idx);
        logic [2:0]  m  = v[54:52];
        logic [7:0]  fi = v[25:18];
        logic [15:0] ep = v[17:2];
        logic        ec = v[1];
        logic        ei = v[0];
        string       tag;
        mode    = m;
        dst_idx = v[51:47];
        src_idx = v[46:42];
        dst_val = v[41:34];
        src_val = v[33:26];
        sr_in   = fi;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (ei) begin
            tag = $sformatf("R10 vec%0d", idx);
            check({tag, " pulses"}, {30'b0, illegal, done}, 32'b10);
            check({tag, " product held"}, product, last_prod);
            check({tag, " flags held"}, sr_out, last_sr);
        end else begin
            tag = (m[2]) ? $sformatf("R9 vec%0d", idx) :
                  (m[1:0] == 2'd0) ? $sformatf("R2 vec%0d", idx) :
                  (m[1:0] == 2'd1) ? $sformatf("R3 vec%0d", idx) :
                                     $sformatf("R4 vec%0d", idx);
            check({tag, " R8 done"}, {30'b0, illegal, done}, 32'b01);
            check({tag, " product"}, product, ep);
            check({tag, " R5 R6 R7 flags"}, sr_out, exp_sr(fi, ep, ec));
            last_prod = ep;
            last_sr   = exp_sr(fi, ep, ec);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset outputs", {7'b0, done, illegal, product, sr_out}, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 after reset", {7'b0, done, illegal, product, sr_out}, 32'h0);

        for (int i = 0; i < NV; i++)
            run_vec(VEC[i], i);

        // R11: back-to-back issue; R6: sr_in changes after its start
        mode = 3'd0; dst_idx = 5'd1; src_idx = 5'd2;
        dst_val = 8'h03; src_val = 8'h05; sr_in = 8'h00; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mode = 3'd1; dst_idx = 5'd16; src_idx = 5'd16;
        dst_val = 8'hFE; src_val = 8'h03; sr_in = 8'hA0;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; sr_in = 8'h00;
        check("R11 first done", {31'b0, done}, 32'h1);
        check("R11 first product", product, 16'h000F);
        check("R11 first flags", sr_out, 8'h00);
        @(posedge clk);
        @(negedge clk);
        check("R11 second done", {31'b0, done}, 32'h1);
        check("R11 second product", product, 16'hFFFA);
        check("R6 captured status", sr_out, 8'hA1);
        @(posedge clk);
        @(negedge clk);
        check("R8 no done without start", {30'b0, done, illegal}, 32'h0);
        check("R8 outputs held", product, 16'hFFFA);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule